// File: doc/BRIEF.md
# Reference-Clocked Digital Phase Detector

This block produces the phase error of a phase-domain all-digital PLL while running entirely on the uniform reference clock; no oscillator-retimed clock drives any of its logic. Each reference cycle it takes three inputs. The first is a free-running count of oscillator rising edges, already brought into the reference domain. The second is a fractional measurement from a time-to-digital converter: the delay from the most recent oscillator rising edge to the reference edge, in units of one oscillator period. The third is the frequency command word, which gives the wanted number of oscillator periods per reference period.

The reference phase advances by the command word every cycle. The variable phase takes its integer part from the change in the edge count. The count taken over one reference cycle holds one more than the whole oscillator periods in that cycle. The start-of-cycle fraction is approximated as one minus the previous end-of-cycle fraction, so the fractional path reduces to the difference between successive converter samples, and the extra edge cancels. The constant left by the first sample is dropped, because the loop absorbs a fixed offset. The signed difference of the two phases goes to the loop filter.

All phases are 32-bit words with 16 fractional bits and wrap modulo 2^32. The first cycle after reset only captures the starting edge count and fraction. From the next cycle on, a registered error with a valid flag is produced every cycle.

Top module: `ref_phase_detector`

## Requirements
- R1: While `rst` is high at a rising clock edge, `err_valid` becomes 0 and `phase_err` becomes 0 after that edge.
- R2: At the first rising edge with `rst` low after a reset, `edge_cnt` and `tdc_frac` are captured as the starting point, and `phase_err` stays 0 with `err_valid` 0.
- R3: From the second rising edge after reset onward, `err_valid` is 1 after every edge until the next reset.
- R4: When `edge_cnt` and `tdc_frac` do not change between edges, `phase_err` grows by the zero-extended `fcw` (format 8.16, placed so that the fractional bits of `fcw` line up with bits 15:0 of the phase) on every edge.
- R5: An increase of `edge_cnt` by d between edges lowers `phase_err` by d × 2^16 modulo 2^32.
- R6: A change of `tdc_frac` (unsigned 0.16 fraction) between edges lowers `phase_err` by the new value minus the old value, taken in 16.16 format, so the error after k accumulating edges is sum(fcw) − ((cnt_k − cnt_0) << 16) − (frac_k − frac_0), modulo 2^32.
- R7: All arithmetic wraps modulo 2^32, including wrap of `edge_cnt` from 0xFFFFFFFF to 0, and `phase_err` is the two's-complement reading of the wrapped difference.
- R8: The absolute starting values of `edge_cnt` and `tdc_frac` do not affect `phase_err`; only their changes since the captured start do.
- R9: When the edge count and fraction follow a variable phase that advances by exactly `fcw` per cycle (count = integer part, fraction = fractional part), `phase_err` stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| fcw | input | 24 | Frequency command word, unsigned 8.16 |
| edge_cnt | input | 32 | Oscillator rising-edge count, synchronized |
| tdc_frac | input | 16 | Edge-to-reference delay, unsigned 0.16 |
| phase_err | output | 32 | Signed phase error, 16.16 |
| err_valid | output | 1 | Phase error is meaningful |

## Verification
Inputs applied before a rising edge show up in `phase_err` and `err_valid` right after that same edge, because there is one register stage. The bench drives inputs on the falling edge, waits for the next rising edge and samples on the following falling edge, so every check sees the result of exactly one update. Expected errors come from a closed form: the running sum of command words minus the scaled count change and fraction change since the captured start. This is independent of the design's incremental accumulation. The reset and priming cycles are checked at the same falling-edge points.

// File: rtl/ref_phase_detector.sv
module ref_phase_detector #(
  parameter int FCW_INT_W = 8,
  parameter int FRAC_W    = 16,
  parameter int CNT_W     = 32,
  parameter int PH_W      = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [FCW_INT_W+FRAC_W-1:0] fcw,
  input  logic [CNT_W-1:0]            edge_cnt,
  input  logic [FRAC_W-1:0]           tdc_frac,
  output logic signed [PH_W-1:0]      phase_err,
  output logic                        err_valid
);

  logic             primed;
  logic [CNT_W-1:0] cnt_q;
  logic [FRAC_W-1:0] frac_q;
  logic [PH_W-1:0]  ph_ref, ph_var, err_q;

  logic [CNT_W-1:0] cnt_step;
  logic [PH_W-1:0]  int_step, frac_step, ref_next, var_next;

  assign cnt_step  = edge_cnt - cnt_q;
  assign int_step  = PH_W'(cnt_step) << FRAC_W;
  assign frac_step = PH_W'(tdc_frac) - PH_W'(frac_q);
  assign ref_next  = ph_ref + PH_W'(fcw);
  assign var_next  = ph_var + int_step + frac_step;

  always_ff @(posedge clk) begin
    if (rst) begin
      primed    <= 1'b0;
      cnt_q     <= '0;
      frac_q    <= '0;
      ph_ref    <= '0;
      ph_var    <= '0;
      err_q     <= '0;
      err_valid <= 1'b0;
    end else begin
      primed <= 1'b1;
      cnt_q  <= edge_cnt;
      frac_q <= tdc_frac;
      if (primed) begin
        ph_ref    <= ref_next;
        ph_var    <= var_next;
        err_q     <= ref_next - var_next;
        err_valid <= 1'b1;
      end
    end
  end

  assign phase_err = err_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!err_valid && err_q == '0));

  // R2
  prime_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !primed |=> (!err_valid && err_q == '0));

  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    primed |=> err_valid);

  // R4
  ref_only_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && edge_cnt == $past(edge_cnt) && tdc_frac == $past(tdc_frac))
    |=> err_q == $past(err_q) + PH_W'($past(fcw)));

  // R6
  step_law_chk: assert property (@(posedge clk) disable iff (rst)
    primed |=> err_q == $past(err_q) + PH_W'($past(fcw))
      - (PH_W'($past(edge_cnt) - $past(edge_cnt, 2)) << FRAC_W)
      - (PH_W'($past(tdc_frac)) - PH_W'($past(tdc_frac, 2))));

endmodule

// File: tb/test_ref_phase_detector.sv
`timescale 1ns/1ps
module test_ref_phase_detector;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [23:0] fcw = '0;
  logic [31:0] edge_cnt = '0;
  logic [15:0] tdc_frac = '0;
  logic signed [31:0] phase_err;
  logic err_valid;

  int checks = 0;
  int fails  = 0;

  logic        m_primed;
  logic [31:0] m_ref, m_cnt0, m_frac0;

  always #2 clk = ~clk;

  ref_phase_detector i_ref_phase_detector (
    .clk(clk), .rst(rst), .fcw(fcw), .edge_cnt(edge_cnt),
    .tdc_frac(tdc_frac), .phase_err(phase_err), .err_valid(err_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 valid", {31'b0, err_valid}, 32'd0);
    chk("R1 err", phase_err, 32'd0);
    rst = 1'b0;
    m_primed = 1'b0;
  endtask

  task automatic step(input string req, input logic [23:0] f, input logic [31:0] c, input logic [15:0] x);
    logic [31:0] exp;
    fcw = f; edge_cnt = c; tdc_frac = x;
    @(posedge clk);
    @(negedge clk);
    if (!m_primed) begin
      m_primed = 1'b1; m_ref = '0; m_cnt0 = c; m_frac0 = {16'b0, x};
      chk("R2 valid", {31'b0, err_valid}, 32'd0);
      chk("R2 err", phase_err, 32'd0);
    end else begin
      m_ref = m_ref + {8'b0, f};
      exp = m_ref - ((c - m_cnt0) << 16) - ({16'b0, x} - m_frac0);
      chk("R3 valid", {31'b0, err_valid}, 32'd1);
      chk(req, phase_err, exp);
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] c;
    logic [15:0] x;
    logic [31:0] v;
    do_reset();
    // R4: constant count and fraction, swept command words
    for (int f = 0; f < 16; f++) begin
      do_reset();
      step("R4", 24'(f * 24'h0f3a11 + 1), 32'h1234, 16'h4000);
      for (int k = 0; k < 6; k++) step("R4", 24'(f * 24'h0f3a11 + 1), 32'h1234, 16'h4000);
    end
    // R5 and R6: count deltas 0..3 with fraction steps, several start points (R8)
    for (int s = 0; s < 4; s++) begin
      do_reset();
      c = 32'(s * 32'h01000003);
      x = 16'(s * 16'h3333);
      step("R8", 24'h02_8000, c, x);
      for (int d = 0; d < 4; d++)
        for (int q = 0; q < 8; q++) begin
          c = c + 32'(d);
          x = x + 16'(q * 16'h1d01);
          step("R5 R6", 24'(24'h01_0000 + q * 24'h2000), c, x);
        end
    end
    // R7: count wrap and reference phase wrap with maximal command word
    do_reset();
    c = 32'hffff_fff0;
    step("R7", 24'hff_ffff, c, 16'h0);
    for (int k = 0; k < 300; k++) begin
      c = c + 32'd1;
      step("R7", 24'hff_ffff, c, 16'h8000 ^ 16'(k));
    end
    // R9: lock, variable phase follows the command word exactly
    for (int f = 0; f < 8; f++) begin
      do_reset();
      v = 32'(f * 32'h0003_7b15 + 32'hfffe_0000);
      step("R9", 24'(24'h02_4000 + f * 24'h1_1111), v >> 16, v[15:0]);
      for (int k = 0; k < 12; k++) begin
        v = v + {8'b0, 24'(24'h02_4000 + f * 24'h1_1111)};
        step("R9", 24'(24'h02_4000 + f * 24'h1_1111), v >> 16, v[15:0]);
        chk("R9 zero", phase_err, 32'd0);
      end
    end
    // R1: reset in mid-run clears state
    do_reset();
    step("R2", 24'h03_0000, 32'h77, 16'h1);
    step("R4", 24'h03_0000, 32'h77, 16'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule